// File: doc/BRIEF.md
# Escalating Supervisor Watchdog

This block is a supervisor state machine that watches a remote unit for signs of life and steps in when the unit goes quiet. It runs in one of two modes. In polled mode it issues a poll strobe once per period and expects an "okay" answer within a response window. In heartbeat mode it expects the unit to send an okay pulse on its own at least once per period plus travel time and margin. All timing counts ticks from an external timebase, normally 1 ms.

When an answer is missing, or a link, receive or transmit failure flag arrives, the supervisor escalates one stage at a time. It raises an interrupt request first, then a non-maskable interrupt request, and finally a reset recovery. An okay pulse at any stage returns it to monitoring. A packet classifier can also request recovery actions of three strengths: reload, reset with reload, or power cycle with reload. Two recoveries are never allowed to run back to back: a hold-off window follows each one, and a request that arrives inside that window is kept and run when the window ends. After a reset or power cycle the unit gets a fixed reinitialization grace period. A saturating 8-bit counter records every recovery that has been run. When it reaches a configured limit, the block declares the unit permanently failed and stops.

Top module: `esc_watchdog`

## Requirements
- R1: In polled mode (`hb_mode`=0), while monitoring, `poll_strobe` pulses for one cycle on every PERIOD_TICKS-th tick.
- R2: In polled mode, if no `okay` arrives within RESP = TRAVEL_TICKS+MARGIN_TICKS ticks after a poll strobe, `irq_req` goes high.
- R3: In heartbeat mode (`hb_mode`=1), PERIOD_TICKS+TRAVEL_TICKS+MARGIN_TICKS ticks without `okay` raise `irq_req`. Each `okay` restarts that count.
- R4: If `irq_req` lasts RESP ticks without `okay`, it is replaced by `nmi_req`. If `nmi_req` also lasts RESP ticks, a reset recovery (code 2) is requested.
- R5: `okay` during the interrupt or NMI stage, or in the same cycle as a stage timeout, returns the block to monitoring with its stage timer cleared.
- R6: `link_fail` sets `unit_blocked`, and `rx_fail` or `tx_fail` sets `sup_blocked`. Each flag stays set until a later `okay` clears it, and a set in the same cycle wins. Any of these failure inputs during monitoring raises `irq_req`.
- R7: Recovery codes on `rec_kind` are 1 = reload, 2 = reset plus reload, 3 = power cycle plus reload, and 0 = none. Running a recovery produces one-cycle pulses: `reload_req` always, plus `reset_req` for code 2 or `pwrcyc_req` for code 3.
- R8: A recovery runs only once HOLDOFF_TICKS ticks have passed since the previous one. Requests that arrive earlier are latched, the strongest code is kept, and it runs as soon as the window closes.
- R9: After a code 2 or 3 recovery, the block waits REINIT_TICKS ticks before it resumes monitoring. During that wait it neither polls nor escalates, and `okay` is ignored.
- R10: `rec_count` rises by one for each recovery run and saturates at 255. When it reaches FAIL_LIMIT, `perm_fail` goes high and stays high, and monitoring stops.
- R11: After reset all outputs are zero and the block is monitoring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase tick, one cycle wide |
| hb_mode | input | 1 | 0 = polled, 1 = heartbeat |
| okay | input | 1 | Unit reports healthy |
| link_fail | input | 1 | Link connection timeout |
| rx_fail | input | 1 | Receive packet timeout |
| tx_fail | input | 1 | Transmit packet timeout |
| rec_valid | input | 1 | Classifier recovery request strobe |
| rec_kind | input | 2 | Classifier recovery code |
| poll_strobe | output | 1 | Poll request pulse |
| irq_req | output | 1 | Interrupt request stage |
| nmi_req | output | 1 | Non-maskable interrupt stage |
| reset_req | output | 1 | Reset command pulse |
| pwrcyc_req | output | 1 | Power cycle command pulse |
| reload_req | output | 1 | Program reload command pulse |
| unit_blocked | output | 1 | Unit interface blocked |
| sup_blocked | output | 1 | Supervisor interface blocked |
| rec_count | output | 8 | Recoveries applied, saturating |
| perm_fail | output | 1 | Permanent failure, switch unit off |

## Verification
Two collisions matter most. The first is an okay pulse in the same cycle as a stage timeout. The bench provokes it in heartbeat mode by reading the model's timer and driving `okay` on exactly the tick that would expire, then expects monitoring to continue with no `irq_req`. The second is a classifier request that lands inside the hold-off window of an escalation-driven reset. There the bench expects the request to wait until the window closes and the stronger code to win. Both cases are judged against a cycle-by-cycle model on every clock.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

    typedef enum logic [2:0] {
        ST_WATCH  = 3'd0,
        ST_IRQ    = 3'd1,
        ST_NMI    = 3'd2,
        ST_REINIT = 3'd3,
        ST_OFF    = 3'd4
    } sup_state_t;

    typedef enum logic [1:0] {
        RK_NONE   = 2'd0,
        RK_RELOAD = 2'd1,
        RK_RESET  = 2'd2,
        RK_POWER  = 2'd3
    } rec_kind_t;

    typedef struct packed {
        logic reset;
        logic power;
        logic reload;
    } rec_cmd_t;

    function automatic rec_kind_t kind_max(rec_kind_t a, rec_kind_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic rec_cmd_t kind_to_cmd(rec_kind_t k);
        rec_cmd_t c;
        c.reload = (k != RK_NONE);
        c.reset  = (k == RK_RESET);
        c.power  = (k == RK_POWER);
        return c;
    endfunction

endpackage

// File: rtl/wdsup_tick_timer.sv
module wdsup_tick_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = step && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (step)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wdsup_holdoff.sv
module wdsup_holdoff #(
    parameter int W     = 16,
    parameter int TICKS = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic tick,
    output logic idle
);
    logic [W-1:0] left;

    assign idle = (left == '0);

    always_ff @(posedge clk) begin
        if (rst)                left <= '0;
        else if (load)          left <= W'(TICKS);
        else if (tick && !idle) left <= left - 1'b1;
    end
endmodule

// File: rtl/esc_watchdog.sv
module esc_watchdog
    import wdsup_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int PERIOD_TICKS = 1000,
    parameter int TRAVEL_TICKS = 20,
    parameter int MARGIN_TICKS = 50,
    parameter int REINIT_TICKS = 5000,
    parameter int HOLDOFF_TICKS = 10000,
    parameter int FAIL_LIMIT   = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       hb_mode,
    input  logic       okay,
    input  logic       link_fail,
    input  logic       rx_fail,
    input  logic       tx_fail,
    input  logic       rec_valid,
    input  logic [1:0] rec_kind,
    output logic       poll_strobe,
    output logic       irq_req,
    output logic       nmi_req,
    output logic       reset_req,
    output logic       pwrcyc_req,
    output logic       reload_req,
    output logic       unit_blocked,
    output logic       sup_blocked,
    output logic [7:0] rec_count,
    output logic       perm_fail
);
    localparam logic [CNT_W-1:0] RESP_L   = CNT_W'(TRAVEL_TICKS + MARGIN_TICKS);
    localparam logic [CNT_W-1:0] HB_L     = CNT_W'(PERIOD_TICKS + TRAVEL_TICKS + MARGIN_TICKS);
    localparam logic [CNT_W-1:0] PERIOD_L = CNT_W'(PERIOD_TICKS);
    localparam logic [CNT_W-1:0] REINIT_L = CNT_W'(REINIT_TICKS);
    localparam logic [7:0]       LIMIT_L  = 8'(FAIL_LIMIT);

    sup_state_t state, nstate;
    rec_kind_t  pend, pend_n;
    rec_cmd_t   cmd_q;
    logic       awaiting, awaiting_n;
    logic       poll_q;
    logic [7:0] cnt_q, cnt_inc;

    logic fault, fire, esc, strobe_c, ho_idle;
    logic st_step, st_clr, st_done;
    logic pc_step, pc_clr, pc_done;
    logic [CNT_W-1:0] st_limit;

    assign fault   = link_fail | rx_fail | tx_fail;
    assign cnt_inc = (cnt_q == 8'hFF) ? cnt_q : cnt_q + 8'd1;
    assign fire    = (pend != RK_NONE) && ho_idle &&
                     (state == ST_WATCH || state == ST_IRQ || state == ST_NMI);

    always_comb begin
        unique case (state)
            ST_WATCH:  st_limit = hb_mode ? HB_L : RESP_L;
            ST_REINIT: st_limit = REINIT_L;
            default:   st_limit = RESP_L;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_WATCH:                 st_step = tick && (hb_mode || awaiting);
            ST_IRQ, ST_NMI, ST_REINIT: st_step = tick;
            default:                  st_step = 1'b0;
        endcase
    end

    always_comb begin
        nstate = state;
        esc    = 1'b0;
        if (fire) begin
            if (cnt_inc >= LIMIT_L)  nstate = ST_OFF;
            else if (pend >= RK_RESET) nstate = ST_REINIT;
            else                     nstate = ST_WATCH;
        end else begin
            unique case (state)
                ST_WATCH:  if ((st_done || fault) && !okay) nstate = ST_IRQ;
                ST_IRQ:    if (okay) nstate = ST_WATCH;
                           else if (st_done) nstate = ST_NMI;
                ST_NMI:    if (okay) nstate = ST_WATCH;
                           else if (st_done) begin
                               nstate = ST_WATCH;
                               esc    = 1'b1;
                           end
                ST_REINIT: if (st_done) nstate = ST_WATCH;
                default:   nstate = state;
            endcase
        end
    end

    always_comb begin
        pend_n = fire ? RK_NONE : pend;
        if (esc)       pend_n = kind_max(pend_n, RK_RESET);
        if (rec_valid) pend_n = kind_max(pend_n, rec_kind_t'(rec_kind));
    end

    assign pc_step  = tick && (state == ST_WATCH) && !hb_mode;
    assign pc_clr   = (state != ST_WATCH) || fire || (nstate != ST_WATCH) || pc_done;
    assign strobe_c = pc_done && (state == ST_WATCH) && !fire && (nstate == ST_WATCH);
    assign st_clr   = fire || (nstate != state) ||
                      ((state == ST_WATCH) && (strobe_c || okay));

    always_comb begin
        if (fire || state != ST_WATCH || nstate != ST_WATCH) awaiting_n = 1'b0;
        else if (strobe_c)                                  awaiting_n = 1'b1;
        else if (okay)                                      awaiting_n = 1'b0;
        else                                                awaiting_n = awaiting;
    end

    wdsup_tick_timer #(.W(CNT_W)) u_stage (
        .clk(clk), .rst(rst), .clr(st_clr), .step(st_step),
        .limit(st_limit), .done(st_done)
    );

    wdsup_tick_timer #(.W(CNT_W)) u_period (
        .clk(clk), .rst(rst), .clr(pc_clr), .step(pc_step),
        .limit(PERIOD_L), .done(pc_done)
    );

    wdsup_holdoff #(.W(CNT_W), .TICKS(HOLDOFF_TICKS)) u_holdoff (
        .clk(clk), .rst(rst), .load(fire), .tick(tick), .idle(ho_idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_WATCH;
            pend         <= RK_NONE;
            awaiting     <= 1'b0;
            poll_q       <= 1'b0;
            cmd_q        <= '0;
            cnt_q        <= '0;
            unit_blocked <= 1'b0;
            sup_blocked  <= 1'b0;
        end else begin
            state    <= nstate;
            pend     <= pend_n;
            awaiting <= awaiting_n;
            poll_q   <= strobe_c;
            cmd_q    <= fire ? kind_to_cmd(pend) : '0;
            if (fire) cnt_q <= cnt_inc;
            if (link_fail)           unit_blocked <= 1'b1;
            else if (okay)           unit_blocked <= 1'b0;
            if (rx_fail || tx_fail)  sup_blocked  <= 1'b1;
            else if (okay)           sup_blocked  <= 1'b0;
        end
    end

    assign poll_strobe = poll_q;
    assign irq_req     = (state == ST_IRQ);
    assign nmi_req     = (state == ST_NMI);
    assign reset_req   = cmd_q.reset;
    assign pwrcyc_req  = cmd_q.power;
    assign reload_req  = cmd_q.reload;
    assign rec_count   = cnt_q;
    assign perm_fail   = (state == ST_OFF);
endmodule

// File: rtl/esc_watchdog_chk.sv
module esc_watchdog_chk (
    input logic       clk,
    input logic       rst,
    input logic       okay,
    input logic       poll_strobe,
    input logic       irq_req,
    input logic       nmi_req,
    input logic       reset_req,
    input logic       pwrcyc_req,
    input logic       reload_req,
    input logic [7:0] rec_count,
    input logic       perm_fail
);
    // R4: the NMI stage is entered only from the interrupt stage
    p_nmi_after_irq_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_req) |-> $past(irq_req));

    // R5: okay during an escalation stage leaves that stage
    p_okay_returns_r5: assert property (@(posedge clk) disable iff (rst)
        (okay && (irq_req || nmi_req)) |=> (!irq_req && !nmi_req));

    // R7: reset and power cycle are exclusive and always come with reload
    p_cmd_shape_r7: assert property (@(posedge clk) disable iff (rst)
        (reset_req || pwrcyc_req) |-> (reload_req && !(reset_req && pwrcyc_req)));

    // R8: no two recovery pulses on consecutive cycles
    p_no_back_to_back_r8: assert property (@(posedge clk) disable iff (rst)
        reload_req |=> !reload_req);

    // R9: no escalation in the cycle a reset or power cycle is issued
    p_reinit_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (reset_req || pwrcyc_req) |-> (!irq_req && !nmi_req && !poll_strobe));

    // R10: count never falls, moves by at most one
    p_count_step_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rec_count == $past(rec_count) ||
                         rec_count == $past(rec_count) + 8'd1));

    // R10: permanent failure is sticky
    p_perm_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        perm_fail |=> perm_fail);
endmodule

bind esc_watchdog esc_watchdog_chk u_chk (
    .clk(clk), .rst(rst), .okay(okay), .poll_strobe(poll_strobe),
    .irq_req(irq_req), .nmi_req(nmi_req), .reset_req(reset_req),
    .pwrcyc_req(pwrcyc_req), .reload_req(reload_req),
    .rec_count(rec_count), .perm_fail(perm_fail)
);

// File: tb/test_esc_watchdog.sv
module test_esc_watchdog;
    localparam int PER    = 20;
    localparam int TRV    = 2;
    localparam int MRG    = 3;
    localparam int REIN   = 15;
    localparam int HOLD   = 40;
    localparam int LIMIT  = 4;
    localparam int RESP   = TRV + MRG;
    localparam int HB     = PER + TRV + MRG;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, hb_mode = 1'b0, okay = 1'b0;
    logic link_fail = 1'b0, rx_fail = 1'b0, tx_fail = 1'b0;
    logic rec_valid = 1'b0;
    logic [1:0] rec_kind = 2'd0;
    logic poll_strobe, irq_req, nmi_req, reset_req, pwrcyc_req, reload_req;
    logic unit_blocked, sup_blocked, perm_fail;
    logic [7:0] rec_count;

    always #5 clk = ~clk;

    esc_watchdog #(
        .CNT_W(16), .PERIOD_TICKS(PER), .TRAVEL_TICKS(TRV), .MARGIN_TICKS(MRG),
        .REINIT_TICKS(REIN), .HOLDOFF_TICKS(HOLD), .FAIL_LIMIT(LIMIT)
    ) i_esc_watchdog (
        .clk(clk), .rst(rst), .tick(tick), .hb_mode(hb_mode), .okay(okay),
        .link_fail(link_fail), .rx_fail(rx_fail), .tx_fail(tx_fail),
        .rec_valid(rec_valid), .rec_kind(rec_kind),
        .poll_strobe(poll_strobe), .irq_req(irq_req), .nmi_req(nmi_req),
        .reset_req(reset_req), .pwrcyc_req(pwrcyc_req), .reload_req(reload_req),
        .unit_blocked(unit_blocked), .sup_blocked(sup_blocked),
        .rec_count(rec_count), .perm_fail(perm_fail)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R11";
    int cycles = 0;
    int tick_ctr = 0;
    bit auto_ans = 0, auto_hb = 0, compare_on = 0;

    // behavioural model: 0 watch, 1 irq, 2 nmi, 3 reinit, 4 off
    int m_st, m_stg, m_pc, m_pend, m_ho, m_cnt;
    bit m_await, m_poll, m_rst, m_pwr, m_rld, m_ub, m_sb;
    bit fault_b, fire_b, esc_b, to_b, strobe_b;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_stg = 0; m_pc = 0; m_pend = 0; m_ho = 0; m_cnt = 0;
            m_await = 0; m_poll = 0; m_rst = 0; m_pwr = 0; m_rld = 0; m_ub = 0; m_sb = 0;
        end else begin
            m_poll = 0; m_rst = 0; m_pwr = 0; m_rld = 0;
            fault_b = link_fail || rx_fail || tx_fail;
            fire_b  = (m_pend != 0) && (m_ho == 0) && (m_st <= 2);
            esc_b   = 0;
            if (fire_b) begin
                m_rld = 1; m_rst = (m_pend == 2); m_pwr = (m_pend == 3);
                m_cnt = (m_cnt < 255) ? m_cnt + 1 : 255;
                if (m_cnt >= LIMIT) m_st = 4;
                else if (m_pend >= 2) m_st = 3;
                else m_st = 0;
                m_stg = 0; m_pc = 0; m_await = 0; m_pend = 0;
                m_ho = HOLD;
            end else begin
                if (tick && m_ho > 0) m_ho = m_ho - 1;
                case (m_st)
                    0: begin
                        to_b = 0; strobe_b = 0;
                        if (hb_mode) begin
                            if (tick) begin if (m_stg == HB - 1) to_b = 1; else m_stg++; end
                        end else begin
                            if (tick && m_await) begin if (m_stg == RESP - 1) to_b = 1; else m_stg++; end
                            if (tick) begin if (m_pc == PER - 1) begin strobe_b = 1; m_pc = 0; end else m_pc++; end
                        end
                        if ((to_b || fault_b) && !okay) begin
                            m_st = 1; m_stg = 0; m_pc = 0; m_await = 0;
                        end else if (strobe_b) begin
                            m_poll = 1; m_await = 1; m_stg = 0;
                        end else if (okay) begin
                            m_await = 0; m_stg = 0;
                        end
                    end
                    1: if (okay) begin m_st = 0; m_stg = 0; end
                       else if (tick) begin if (m_stg == RESP - 1) begin m_st = 2; m_stg = 0; end else m_stg++; end
                    2: if (okay) begin m_st = 0; m_stg = 0; end
                       else if (tick) begin if (m_stg == RESP - 1) begin m_st = 0; m_stg = 0; esc_b = 1; end else m_stg++; end
                    3: if (tick) begin if (m_stg == REIN - 1) begin m_st = 0; m_stg = 0; end else m_stg++; end
                    default: ;
                endcase
            end
            if (esc_b && m_pend < 2) m_pend = 2;
            if (rec_valid && int'(rec_kind) > m_pend) m_pend = int'(rec_kind);
            if (link_fail) m_ub = 1; else if (okay) m_ub = 0;
            if (rx_fail || tx_fail) m_sb = 1; else if (okay) m_sb = 0;
        end
    end

    task automatic cmp(string nm, int act, int exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", cur_req, nm, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (compare_on && !rst) begin
            checks++;
            cmp("poll_strobe R1", poll_strobe, m_poll);
            cmp("irq_req R2", irq_req, m_st == 1);
            cmp("nmi_req R4", nmi_req, m_st == 2);
            cmp("reset_req R7", reset_req, m_rst);
            cmp("pwrcyc_req R7", pwrcyc_req, m_pwr);
            cmp("reload_req R7", reload_req, m_rld);
            cmp("unit_blocked R6", unit_blocked, m_ub);
            cmp("sup_blocked R6", sup_blocked, m_sb);
            cmp("rec_count R10", rec_count, m_cnt);
            cmp("perm_fail R10", perm_fail, m_st == 4);
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        okay = 0; link_fail = 0; rx_fail = 0; tx_fail = 0; rec_valid = 0; rec_kind = 2'd0;
        tick = (tick_ctr % 2 == 1);
        tick_ctr++;
        if (auto_ans && poll_strobe) okay = 1;
        if (auto_hb && (tick_ctr % 30 == 0)) okay = 1;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic named(string req, string nm, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, nm, act, exp);
        end
    endtask

    int strobes;
    int k;

    initial begin
        run(4);
        rst = 0;
        step();
        // R11: reset state
        cur_req = "R11";
        named("R11", "outputs after reset",
              {poll_strobe, irq_req, nmi_req, reset_req, pwrcyc_req, reload_req,
               unit_blocked, sup_blocked, perm_fail, rec_count}, 0);
        compare_on = 1;

        // R1: polled mode, answered polls
        cur_req = "R1";
        auto_ans = 1; strobes = 0;
        for (int i = 0; i < 3 * 2 * PER + 4; i++) begin step(); if (poll_strobe) strobes++; end
        named("R1", "poll strobes in three periods", strobes, 3);
        named("R1", "no escalation while answered", irq_req, 0);

        // R2 + R5: unanswered poll, then okay in the interrupt stage
        cur_req = "R2";
        auto_ans = 0;
        k = 0;
        while (!irq_req && k < 200) begin step(); k++; end
        named("R2", "irq after missed answer", irq_req, 1);
        cur_req = "R5";
        run(3); okay = 1; step();
        named("R5", "okay returns to monitoring", irq_req, 0);

        // R4 + R9: full escalation to reset, okay ignored in grace
        cur_req = "R4";
        k = 0;
        while (!reset_req && k < 400) begin step(); k++; end
        named("R4", "reset after nmi timeout", reset_req, 1);
        cur_req = "R9";
        okay = 1; step(); run(2 * REIN - 6);
        named("R9", "no poll/irq during grace", irq_req | poll_strobe, 0);

        // R8: classifier requests inside hold-off; strongest kept
        cur_req = "R8";
        rec_valid = 1; rec_kind = 2'd1; step();
        rec_valid = 1; rec_kind = 2'd3; step();
        auto_ans = 1;
        k = 0;
        while (!reload_req && k < 300) begin step(); k++; end
        named("R8", "power cycle after hold-off", pwrcyc_req, 1);
        named("R8", "hold-off length respected", (k >= 2 * HOLD - 2 * REIN - 8) ? 1 : 0, 1);
        run(2 * REIN + 4);

        // R3: heartbeat mode, kept alive then silent
        cur_req = "R3";
        hb_mode = 1; auto_ans = 0; auto_hb = 1;
        okay = 1; step();
        run(150);
        named("R3", "heartbeats keep it quiet", irq_req, 0);
        // R5: okay on the exact timeout tick
        cur_req = "R5";
        auto_hb = 0;
        k = 0;
        while (!(m_st == 0 && m_stg == HB - 1 && tick) && k < 200) begin step(); k++; end
        okay = 1; step(); step();
        named("R5", "okay wins over same-cycle timeout", irq_req, 0);
        cur_req = "R3";
        k = 0;
        while (!irq_req && k < 200) begin step(); k++; end
        named("R3", "irq after silent period", irq_req, 1);
        okay = 1; step();

        // R6: interface failure flags
        cur_req = "R6";
        auto_hb = 1;
        link_fail = 1; step(); step();
        named("R6", "unit_blocked set", unit_blocked, 1);
        named("R6", "link failure escalates", irq_req, 1);
        rx_fail = 1; step(); step();
        named("R6", "sup_blocked set", sup_blocked, 1);
        okay = 1; step(); step();
        named("R6", "okay clears blocked", unit_blocked | sup_blocked, 0);
        tx_fail = 1; okay = 1; step(); step();
        named("R6", "set wins over okay", sup_blocked, 1);
        run(40);

        // R7: reload-only request
        cur_req = "R7";
        rec_valid = 1; rec_kind = 2'd1; step();
        k = 0;
        while (!reload_req && k < 300) begin step(); k++; end
        named("R7", "reload only, no reset", {reload_req, reset_req, pwrcyc_req}, 3'b100);
        run(10);

        // R10: repeated failures until permanent failure
        cur_req = "R10";
        auto_hb = 0;
        k = 0;
        while (!perm_fail && k < 3000) begin step(); k++; end
        named("R10", "perm_fail reached", perm_fail, 1);
        named("R10", "count at limit", rec_count, LIMIT);
        okay = 1; step(); run(200);
        named("R10", "perm_fail sticky", perm_fail, 1);
        named("R10", "no escalation after off", irq_req | nmi_req, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule